// File: doc/BRIEF.md
# Multi-Source XOR Accumulator with Zero Check

This engine combines up to eight source buffers, one 32-bit word at a time, into a destination buffer. A 32-bit descriptor control word gives each source its own 3-bit command. The first source either loads its memory word straight into the accumulator or supplies a constant that fills the destination. Later sources are XORed into the accumulator. A source whose command is zero is passed over.

For every destination word the sources are visited in ascending index order. Only then is the accumulated word either written to the destination or checked against zero. In zero-check mode the engine can run without writing anything. When the run ends it reports a nonzero result through an error bit in the control word it returns. That returned word also carries a completion bit.

The descriptor (control word, source addresses, destination address and byte count) is sampled on a start pulse. Memory is reached through a single request port, and read data returns exactly one cycle after a read request.

Top module: `xacc_engine`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `irq` and `mem_req` are all low.
- R2: A source-1 command of 7 (control bits 3:1) loads that source's memory word into the accumulator, discarding earlier contents.
- R3: A command of 1 in any source field (source k in control bits 3k+3:3k+1, k = 0..7) XORs that source's word into the accumulator. Word w of a source is read at its base address + 4w. Result word w goes to the destination base + 4w, and sources are visited in ascending order for each word.
- R4: A command of 0, or any code other than 1 on sources 2 to 8, causes no memory read and leaves the accumulator unchanged.
- R5: A source-1 command of 2 sets the accumulator to the source-1 address word itself, with no read for source 1.
- R6: The field in control bits 26:25 limits the sources. Value 0 activates sources 1 to 4 and ignores fields 5 to 8. Values 1, 2 and 3 activate all eight.
- R7: With control bit 31 clear, no destination write is issued. With it set, one write is issued per word.
- R8: With control bit 30 set, returned bit 29 is 1 exactly when at least one accumulated word was nonzero. With bit 30 clear, returned bit 29 is 0.
- R9: On completion `done` is high for exactly one cycle. `ctrl_wb` then equals the sampled control word with bit 28 set and bit 29 as in R8. `irq` pulses with `done` only when control bit 0 is set.
- R10: With control bit 30 set, the run covers at most 1024 bytes (256 words), whatever the byte count.
- R11: The two low bits of the byte count are ignored. If the count is below 4, the run completes with no memory access.
- R12: A start pulse while the engine is busy is ignored, and the descriptor in use does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample descriptor and begin, when idle |
| ctrl_in | input | 32 | Descriptor control word |
| src_addr_in | input | NSRC*AW | Source base addresses, source 1 in the low slice |
| dst_addr_in | input | AW | Destination base address |
| byte_count_in | input | BCW | Bytes to process |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt pulse |
| ctrl_wb | output | 32 | Control word with completion and zero-error bits, valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when set, read when clear |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |

## Verification
On every cycle the assertions check several rules. A destination write never occurs while the write-enable bit is clear. The word counter of a zero-check run stays below 256 words. `done` never lasts two cycles, and the latched control word cannot move while a run is active. The zero-error bit is never returned without zero-check enabled. Data correctness needs the bench's scenarios: the accumulated values across command mixes, the source-count field, block fill, and zero or nonzero outcomes. Read counts show the skipped sources and the 1024-byte cap.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

    // control word bit positions (decoded by the engine)
    localparam int CB_IRQ  = 0;
    localparam int CB_CMD  = 1;
    localparam int CB_BLK  = 25;
    localparam int CB_DONE = 28;
    localparam int CB_ZERR = 29;
    localparam int CB_ZEN  = 30;
    localparam int CB_DWE  = 31;
    localparam int CMDW    = 3;

    localparam logic [CMDW-1:0] CMD_XOR  = 3'd1;
    localparam logic [CMDW-1:0] CMD_FILL = 3'd2;
    localparam logic [CMDW-1:0] CMD_LOAD = 3'd7;

    typedef enum logic [1:0] {
        ACT_SKIP = 2'd0,
        ACT_XOR  = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_FILL = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_CAP,
        ST_WEND,
        ST_DONE
    } st_e;

    function automatic act_e src_action(input logic first, input logic [CMDW-1:0] cmd);
        if (cmd == CMD_XOR)           return ACT_XOR;
        if (first && cmd == CMD_LOAD) return ACT_LOAD;
        if (first && cmd == CMD_FILL) return ACT_FILL;
        return ACT_SKIP;
    endfunction

    function automatic logic [31:0] finish_word(input logic [31:0] c, input logic nonzero);
        logic [31:0] r;
        r          = c;
        r[CB_DONE] = 1'b1;
        r[CB_ZERR] = c[CB_ZEN] & nonzero;
        return r;
    endfunction

endpackage

// File: rtl/xacc_decode.sv
module xacc_decode
    import xacc_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int NARROW = 4,
    localparam int SIW   = $clog2(NSRC),
    localparam int NW    = SIW + 1
) (
    input  logic [NSRC*CMDW-1:0]    cmds,
    input  logic [1:0]              blk,
    output logic [NSRC-1:0][1:0]    acts,
    output logic [SIW-1:0]          last_src
);

    logic [NW-1:0] n_active;

    assign n_active = (blk == 2'b00) ? NW'(NARROW) : NW'(NSRC);
    assign last_src = SIW'(n_active - 1'b1);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign acts[i] = (i < n_active)
                       ? src_action(i == 0, cmds[i*CMDW +: CMDW])
                       : ACT_SKIP;
    end

endmodule

// File: rtl/xacc_core.sv
module xacc_core
    import xacc_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int AW         = 32,
    parameter int BCW        = 24,
    parameter int ZMAX_BYTES = 1024,
    localparam int SIW       = $clog2(NSRC),
    localparam int WW        = BCW - 2,
    localparam int ZWORDS    = ZMAX_BYTES / 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [31:0]             ctrl_in,
    input  logic [NSRC*AW-1:0]      src_in,
    input  logic [AW-1:0]           dst_in,
    input  logic [BCW-1:0]          bcnt_in,
    input  logic [NSRC-1:0][1:0]    acts,
    input  logic [SIW-1:0]          last_src,
    output logic [NSRC*CMDW-1:0]    cmd_q,
    output logic [1:0]              blk_q,
    output logic                    busy,
    output logic                    done,
    output logic                    irq,
    output logic [31:0]             ctrl_wb,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic [31:0]             mem_rdata
);

    st_e            state;
    logic [31:0]    ctrl_q;
    logic [AW-1:0]  src_q [NSRC];
    logic [AW-1:0]  dst_q;
    logic [WW-1:0]  nwords_q;
    logic [WW-1:0]  widx;
    logic [SIW-1:0] sidx;
    logic [31:0]    acc;
    logic           zflag;

    logic [WW-1:0]  nw_raw;
    logic [WW-1:0]  nw_in;
    logic [AW-1:0]  woff;
    act_e           cur_act;
    logic           src_last;
    logic           unused_bcnt_low;

    assign unused_bcnt_low = ^bcnt_in[1:0];
    assign nw_raw   = bcnt_in[BCW-1:2];
    assign nw_in    = (ctrl_in[CB_ZEN] && nw_raw > WW'(ZWORDS)) ? WW'(ZWORDS) : nw_raw;
    assign woff     = AW'({widx, 2'b00});
    assign cur_act  = act_e'(acts[sidx]);
    assign src_last = (sidx == last_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctrl_q   <= '0;
            dst_q    <= '0;
            nwords_q <= '0;
            widx     <= '0;
            sidx     <= '0;
            acc      <= '0;
            zflag    <= 1'b0;
            for (int k = 0; k < NSRC; k++) src_q[k] <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ctrl_q   <= ctrl_in;
                    dst_q    <= dst_in;
                    nwords_q <= nw_in;
                    for (int k = 0; k < NSRC; k++) src_q[k] <= src_in[k*AW +: AW];
                    widx     <= '0;
                    sidx     <= '0;
                    acc      <= '0;
                    zflag    <= 1'b0;
                    state    <= (nw_in == '0) ? ST_DONE : ST_SRC;
                end
                ST_SRC: begin
                    if (cur_act == ACT_XOR || cur_act == ACT_LOAD) begin
                        state <= ST_CAP;
                    end else begin
                        if (cur_act == ACT_FILL) acc <= 32'(src_q[0]);
                        sidx  <= sidx + 1'b1;
                        state <= src_last ? ST_WEND : ST_SRC;
                    end
                end
                ST_CAP: begin
                    acc   <= (cur_act == ACT_LOAD) ? mem_rdata : (acc ^ mem_rdata);
                    sidx  <= sidx + 1'b1;
                    state <= src_last ? ST_WEND : ST_SRC;
                end
                ST_WEND: begin
                    zflag <= zflag | (acc != '0);
                    if (widx == nwords_q - 1'b1) begin
                        state <= ST_DONE;
                    end else begin
                        widx  <= widx + 1'b1;
                        sidx  <= '0;
                        acc   <= '0;
                        state <= ST_SRC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_SRC && (cur_act == ACT_XOR || cur_act == ACT_LOAD))
                    || (state == ST_WEND && ctrl_q[CB_DWE]);
    assign mem_we    = (state == ST_WEND);
    assign mem_addr  = (state == ST_WEND) ? (dst_q + woff) : (src_q[sidx] + woff);
    assign mem_wdata = acc;

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign irq     = done & ctrl_q[CB_IRQ];
    assign ctrl_wb = finish_word(ctrl_q, zflag);
    assign cmd_q   = ctrl_q[CB_CMD +: NSRC*CMDW];
    assign blk_q   = ctrl_q[CB_BLK +: 2];

    AST_DEST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ctrl_q[CB_DWE]);                          // R7
    AST_ZCHK_WORD_CAP: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_q[CB_ZEN]) |-> (widx < WW'(ZWORDS)));               // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctrl_q));                                        // R12
    AST_ZERR_NEEDS_ZEN: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_q[CB_ZEN]) |-> !ctrl_wb[CB_ZERR]);                 // R8

endmodule

// File: rtl/xacc_engine.sv
module xacc_engine
    import xacc_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int NARROW     = 4,
    parameter int AW         = 32,
    parameter int BCW        = 24,
    parameter int ZMAX_BYTES = 1024,
    localparam int SIW       = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [31:0]         ctrl_in,
    input  logic [NSRC*AW-1:0]  src_addr_in,
    input  logic [AW-1:0]       dst_addr_in,
    input  logic [BCW-1:0]      byte_count_in,
    output logic                busy,
    output logic                done,
    output logic                irq,
    output logic [31:0]         ctrl_wb,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata
);

    logic [NSRC*CMDW-1:0]   cmd_q;
    logic [1:0]             blk_q;
    logic [NSRC-1:0][1:0]   acts;
    logic [SIW-1:0]         last_src;

    xacc_decode #(
        .NSRC   (NSRC),
        .NARROW (NARROW)
    ) u_decode (
        .cmds     (cmd_q),
        .blk      (blk_q),
        .acts     (acts),
        .last_src (last_src)
    );

    xacc_core #(
        .NSRC       (NSRC),
        .AW         (AW),
        .BCW        (BCW),
        .ZMAX_BYTES (ZMAX_BYTES)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctrl_in   (ctrl_in),
        .src_in    (src_addr_in),
        .dst_in    (dst_addr_in),
        .bcnt_in   (byte_count_in),
        .acts      (acts),
        .last_src  (last_src),
        .cmd_q     (cmd_q),
        .blk_q     (blk_q),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .ctrl_wb   (ctrl_wb),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/xacc_engine_tb_top.sv
module xacc_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DWE  = 32'h8000_0000;
    localparam logic [31:0] ZEN  = 32'h4000_0000;
    localparam logic [31:0] IRQE = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] d_ctrl = '0;
    logic [31:0] d_src [8];
    logic [31:0] d_dst = '0;
    logic [23:0] d_bc = '0;
    logic [255:0] src_flat;
    logic        busy, done, irq, mem_req, mem_we;
    logic [31:0] ctrl_wb, mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [4096];
    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    int          n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
    string       cur_req = "R1";
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int k = 0; k < 8; k++) src_flat[k*32 +: 32] = d_src[k];

    xacc_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .ctrl_in(d_ctrl),
        .src_addr_in(src_flat), .dst_addr_in(d_dst), .byte_count_in(d_bc),
        .busy(busy), .done(done), .irq(irq), .ctrl_wb(ctrl_wb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected writes and counts reads
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (mem_we) begin
                wr_cnt++;
                if (exp_a.size() == 0) begin
                    check(1'b0, cur_req, "unexpected dest write", mem_addr, 32'h0);
                end else begin
                    logic [31:0] a, d;
                    a = exp_a.pop_front();
                    d = exp_d.pop_front();
                    check(mem_addr == a, cur_req, "dest address", mem_addr, a);
                    check(mem_wdata == d, cur_req, "dest data", mem_wdata, d);
                end
            end else begin
                rd_cnt++;
            end
        end
    end

    function automatic logic [2:0] cf(input int s, input logic [2:0] c);
        return 3'(c);
    endfunction

    function automatic logic [31:0] cmd(input int s, input logic [2:0] c);
        return 32'(c) << (1 + 3*s);
    endfunction

    // reference computation from the requirements
    task automatic model(output int reads, output bit nz);
        int nw, last;
        nw   = int'(d_bc[23:2]);
        if (d_ctrl[30] && nw > 256) nw = 256;
        last = (d_ctrl[26:25] == 2'b00) ? 3 : 7;
        reads = 0;
        nz = 1'b0;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] acc;
            acc = '0;
            for (int s = 0; s <= last; s++) begin
                logic [2:0] c;
                int idx;
                c   = d_ctrl[1 + 3*s +: 3];
                idx = int'(d_src[s] >> 2) + w;
                if (c == 3'd1) begin
                    acc = acc ^ mem[idx]; reads++;
                end else if (s == 0 && c == 3'd7) begin
                    acc = mem[idx]; reads++;
                end else if (s == 0 && c == 3'd2) begin
                    acc = d_src[0];
                end
            end
            if (d_ctrl[31]) begin
                exp_a.push_back(d_dst + 32'(4*w));
                exp_d.push_back(acc);
            end
            if (acc != '0) nz = 1'b1;
        end
    endtask

    task automatic run_op(input string req, input bit inject);
        int er, nw_exp, cyc;
        bit nz;
        logic [31:0] exp_wb, saved;
        cur_req = req;
        model(er, nz);
        nw_exp = exp_a.size();
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (inject) begin
            saved = d_ctrl;
            @(negedge clk);
            d_ctrl = saved ^ 32'h8000_01FE;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
            d_ctrl = saved;
        end
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(done, req, "completion seen", 32'(done), 32'h1);
        exp_wb = (d_ctrl & ~32'h3000_0000) | 32'h1000_0000
               | ((d_ctrl[30] && nz) ? 32'h2000_0000 : 32'h0);
        check(ctrl_wb == exp_wb, req, "returned control word", ctrl_wb, exp_wb);
        check(irq == d_ctrl[0], {req, "/R9"}, "irq with done", 32'(irq), 32'(d_ctrl[0]));
        check(rd_cnt == er, req, "source read count", 32'(rd_cnt), 32'(er));
        check(wr_cnt == nw_exp, req, "dest write count", 32'(wr_cnt), 32'(nw_exp));
        check(exp_a.size() == 0, req, "writes outstanding", 32'(exp_a.size()), 32'h0);
        exp_a.delete();
        exp_d.delete();
        @(negedge clk);
        check(!done && !busy, "R9", "done lasts one cycle", 32'({done, busy}), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_0000;
        for (int k = 0; k < 8; k++) d_src[k] = 32'(k) * 32'h400;
        d_dst = 32'h2000;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !irq && !mem_req, "R1", "outputs in reset",
              32'({busy, done, irq, mem_req}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !irq && !mem_req, "R1", "outputs after reset",
              32'({busy, done, irq, mem_req}), 32'h0);

        // R2: direct load on source 1, irq enabled, stale status bit 29 preset
        d_ctrl = DWE | IRQE | 32'h2000_0000 | cmd(0, 3'd7);
        d_bc   = 24'd16;
        run_op("R2", 1'b0);

        // R3: load then XOR of sources 2..4
        d_ctrl = DWE | cmd(0, 3'd7) | cmd(1, 3'd1) | cmd(2, 3'd1) | cmd(3, 3'd1);
        d_bc   = 24'd32;
        run_op("R3", 1'b0);

        // R6: all eight sources active (field value 1)
        d_ctrl = DWE | IRQE | (32'd1 << 25) | cmd(0, 3'd7);
        for (int s = 1; s < 8; s++) d_ctrl = d_ctrl | cmd(s, 3'd1);
        d_bc   = 24'd12;
        run_op("R6", 1'b0);

        // R6: field value 0 ignores source fields 5..8
        d_ctrl = DWE | cmd(0, 3'd7) | cmd(1, 3'd1);
        for (int s = 4; s < 8; s++) d_ctrl = d_ctrl | cmd(s, 3'd1);
        d_bc   = 24'd20;
        run_op("R6", 1'b0);

        // R4: disabled and unknown codes are skipped (field value 2 = eight sources)
        d_ctrl = DWE | (32'd2 << 25) | cmd(0, 3'd7) | cmd(1, 3'd0) | cmd(2, 3'd1)
               | cmd(3, 3'd5) | cmd(4, 3'd7) | cmd(5, 3'd2) | cmd(7, 3'd1);
        d_bc   = 24'd16;
        run_op("R4", 1'b0);

        // R5: block fill from source-1 address word, then XOR source 2
        d_src[0] = 32'hDEAD_BEEF;
        d_ctrl = DWE | cmd(0, 3'd2) | cmd(1, 3'd1);
        d_bc   = 24'd16;
        run_op("R5", 1'b0);
        // R5: fill alone, constant reaches every destination word
        d_ctrl = DWE | cmd(0, 3'd2);
        run_op("R5", 1'b0);
        d_src[0] = 32'h0;

        // R7: destination write disabled
        d_ctrl = cmd(0, 3'd7) | cmd(1, 3'd1);
        d_bc   = 24'd24;
        run_op("R7", 1'b0);

        // R8: zero check, identical sources give all-zero result
        d_src[1] = d_src[0];
        d_ctrl = ZEN | cmd(0, 3'd7) | cmd(1, 3'd1);
        d_bc   = 24'd64;
        run_op("R8", 1'b0);
        // R8: zero check with differing sources flags an error
        d_src[1] = 32'h400;
        run_op("R8", 1'b0);

        // R10: zero check capped at 1024 bytes even with larger count
        d_ctrl = ZEN | DWE | IRQE | cmd(0, 3'd7) | cmd(1, 3'd1);
        d_bc   = 24'd2048;
        run_op("R10", 1'b0);

        // R11: count below one word and low bits ignored
        d_ctrl = DWE | ZEN | cmd(0, 3'd7) | cmd(1, 3'd1);
        d_bc   = 24'd3;
        run_op("R11", 1'b0);
        d_ctrl = DWE | cmd(0, 3'd7);
        d_bc   = 24'd11;
        run_op("R11", 1'b0);

        // R12: second start while busy is ignored
        d_ctrl = DWE | cmd(0, 3'd7) | cmd(1, 3'd1) | cmd(2, 3'd1);
        d_bc   = 24'd64;
        run_op("R12", 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule